// File: doc/BRIEF.md
# Two-Level Stream Table Address Resolver

This block turns a stream identifier into the byte address of that stream's 64-byte table entry. Software sets up the stream table in memory, either as one flat array of entries or as a two-level structure. In the two-level form, a directory of 8-byte level-1 descriptors points to separate arrays of level-2 entries. The resolver takes the table base and a configuration word along with each lookup. It decides which form applies and, for the two-level form, reads one descriptor over a simple request/response memory port. It then either strobes `done` with the entry address or strobes `fault` with a fault code and, where meaningful, the faulting address.

The stream ID is split at a programmable bit position. The upper part indexes the level-1 directory. The lower part indexes the level-2 array that the descriptor points to, and it is bounds-checked against the descriptor's span. Fetching and decoding the entry itself is left to logic downstream.

Top module: `stream_entry_locator`

## Requirements
- R1: After reset, `lk_ready` is 1 and `done`, `fault` and `rd_req_valid` are 0.
- R2: A stream ID with any bit set at or above position SID_BITS (16 by default) faults with code 1 (bad stream ID) and `fault_addr` 0, in either table form, and issues no memory read.
- R3: The configuration word selects two-level mode only when its format field `tbl_cfg[17:16]` equals 1. Every other value selects linear mode. In two-level mode the split amount is `tbl_cfg[10:6]`. Base, configuration and stream ID are captured when the lookup is accepted.
- R4: In linear mode, `done` is strobed with entry address (base with its low 6 bits cleared) + stream ID × 64, and no memory read is issued.
- R5: In two-level mode, exactly one read is issued, at address (base with low 6 bits cleared) + (stream ID >> split) × 8.
- R6: The returned descriptor carries the span in bits [4:0] and the level-2 pointer in bits [47:6], with the pointer's low 6 bits taken as zero. A span of 0 faults with code 1 and `fault_addr` 0.
- R7: The level-2 index is the low `split` bits of the stream ID. An index greater than 2^span − 1 faults with code 2 (bad entry) and `fault_addr` 0. Otherwise `done` is strobed with entry address pointer + index × 64.
- R8: A response with `rd_rsp_err` set faults with code 3 (fetch fault), and `fault_addr` equals the descriptor address that was read.
- R9: Each accepted lookup produces exactly one one-cycle strobe of either `done` or `fault`, never both. `lk_ready` is low from acceptance until that strobe, and a lookup is accepted only when `lk_ready` is high. `fault_code` is nonzero whenever `fault` is high.
- R10: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays asserted with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Resolver idle, lookup accepted when both high |
| lk_sid | input | SID_W | Stream identifier |
| tbl_base | input | ADDR_W | Stream table base address |
| tbl_cfg | input | CFG_W | Table format and split configuration |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Descriptor read address |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | DESC_W | Level-1 descriptor contents |
| rd_rsp_err | input | 1 | Read response carries a bus error |
| done | output | 1 | One-cycle strobe: entry address valid |
| entry_addr | output | ADDR_W | Resolved entry address |
| fault | output | 1 | One-cycle strobe: lookup faulted |
| fault_code | output | 2 | 1 bad stream ID, 2 bad entry, 3 fetch fault |
| fault_addr | output | ADDR_W | Descriptor address on fetch fault, else 0 |

## Verification
The assertions check the protocol properties on every cycle. They cover the mutual exclusion of `done` and `fault`, the busy window after acceptance, the holding of a stalled descriptor request, the nonzero fault code on a fault, and the 64-byte alignment of every resolved address. The arithmetic needs the bench's scenarios and its reference function. That covers the index split at each split amount, the span bound at exactly 2^span − 1 and one past it, the masked base, the rule that only format value 1 enables two-level mode, and the absence of any memory read for out-of-range IDs.

// File: rtl/stream_locator_pkg.sv
package stream_locator_pkg;

    localparam int DESC_LOG2     = 3;
    localparam int ENTRY_LOG2    = 6;
    localparam int CFG_FMT_LSB   = 16;
    localparam int CFG_FMT_W     = 2;
    localparam int CFG_SPLIT_LSB = 6;
    localparam int SPLIT_W       = 5;
    localparam int SPAN_W        = 5;
    localparam int PTR_LSB       = 6;
    localparam logic [CFG_FMT_W-1:0] FMT_TWO_LEVEL = 2'd1;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_BAD_SID   = 2'd1,
        FLT_BAD_ENTRY = 2'd2,
        FLT_FETCH     = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FETCH,
        ST_WAIT
    } lk_state_e;

    function automatic logic [CFG_FMT_W-1:0] cfg_format(input logic [31:0] cfg);
        return cfg[CFG_FMT_LSB +: CFG_FMT_W];
    endfunction

    function automatic logic [SPLIT_W-1:0] cfg_split(input logic [31:0] cfg);
        return cfg[CFG_SPLIT_LSB +: SPLIT_W];
    endfunction

endpackage

// File: rtl/sid_index_split.sv
module sid_index_split
    import stream_locator_pkg::*;
#(
    parameter int SID_W    = 32,
    parameter int SID_BITS = 16,
    parameter int ADDR_W   = 48
) (
    input  logic [SID_W-1:0]   sid,
    input  logic [ADDR_W-1:0]  base,
    input  logic [SPLIT_W-1:0] split,
    output logic               sid_oob,
    output logic [SID_W-1:0]   l2_idx,
    output logic [ADDR_W-1:0]  l1_addr,
    output logic [ADDR_W-1:0]  lin_addr
);
    localparam int EXT_W = (ADDR_W > SID_W) ? ADDR_W : SID_W;

    logic [ADDR_W-1:0] base_al;
    logic [SID_W-1:0]  l1_idx;
    logic [SID_W-1:0]  low_mask;
    logic [EXT_W-1:0]  l1_ext;
    logic [EXT_W-1:0]  sid_ext;

    assign base_al = {base[ADDR_W-1:ENTRY_LOG2], {ENTRY_LOG2{1'b0}}};

    generate
        if (SID_BITS < SID_W) begin : g_range
            assign sid_oob = |sid[SID_W-1:SID_BITS];
        end else begin : g_full
            assign sid_oob = 1'b0;
        end
    endgenerate

    for (genvar b = 0; b < SID_W; b++) begin : g_mask
        assign low_mask[b] = (b < int'(split));
    end

    assign l1_idx  = sid >> split;
    assign l2_idx  = sid & low_mask;
    assign l1_ext  = EXT_W'(l1_idx) << DESC_LOG2;
    assign sid_ext = EXT_W'(sid) << ENTRY_LOG2;
    assign l1_addr  = base_al + l1_ext[ADDR_W-1:0];
    assign lin_addr = base_al + sid_ext[ADDR_W-1:0];

endmodule

// File: rtl/l1_desc_eval.sv
module l1_desc_eval
    import stream_locator_pkg::*;
#(
    parameter int SID_W  = 32,
    parameter int ADDR_W = 48,
    parameter int DESC_W = 64
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [SID_W-1:0]  l2_idx,
    output logic              span_zero,
    output logic              l2_over,
    output logic [ADDR_W-1:0] ent_addr
);
    localparam int EXT_W = (ADDR_W > SID_W) ? ADDR_W : SID_W;

    logic [SPAN_W-1:0] span;
    logic [ADDR_W-1:0] l2_ptr;
    logic [EXT_W-1:0]  idx_ext;

    assign span      = desc[SPAN_W-1:0];
    assign l2_ptr    = {desc[ADDR_W-1:PTR_LSB], {PTR_LSB{1'b0}}};
    assign span_zero = (span == '0);
    assign l2_over   = |(l2_idx >> span);
    assign idx_ext   = EXT_W'(l2_idx) << ENTRY_LOG2;
    assign ent_addr  = l2_ptr + idx_ext[ADDR_W-1:0];

endmodule

// File: rtl/stream_entry_locator.sv
module stream_entry_locator
    import stream_locator_pkg::*;
#(
    parameter int SID_W    = 32,
    parameter int SID_BITS = 16,
    parameter int ADDR_W   = 48,
    parameter int CFG_W    = 32,
    parameter int DESC_W   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [SID_W-1:0]  lk_sid,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [CFG_W-1:0]  tbl_cfg,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DESC_W-1:0] rd_rsp_data,
    input  logic              rd_rsp_err,
    output logic              done,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic [ADDR_W-1:0] fault_addr
);
    lk_state_e         state_q;
    logic [SID_W-1:0]  sid_q;
    logic [ADDR_W-1:0] base_q;
    logic [SPLIT_W-1:0] split_q;
    logic              two_lvl_q;

    logic              sid_oob;
    logic [SID_W-1:0]  l2_idx;
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] lin_addr;
    logic              span_zero;
    logic              l2_over;
    logic [ADDR_W-1:0] ent_addr;
    logic [31:0]       cfg_word;

    assign cfg_word = 32'(tbl_cfg);

    sid_index_split #(
        .SID_W(SID_W), .SID_BITS(SID_BITS), .ADDR_W(ADDR_W)
    ) split_i (
        .sid(sid_q), .base(base_q), .split(split_q),
        .sid_oob(sid_oob), .l2_idx(l2_idx),
        .l1_addr(l1_addr), .lin_addr(lin_addr)
    );

    l1_desc_eval #(
        .SID_W(SID_W), .ADDR_W(ADDR_W), .DESC_W(DESC_W)
    ) desc_i (
        .desc(rd_rsp_data), .l2_idx(l2_idx),
        .span_zero(span_zero), .l2_over(l2_over), .ent_addr(ent_addr)
    );

    assign lk_ready     = (state_q == ST_IDLE);
    assign rd_req_valid = (state_q == ST_FETCH);
    assign rd_req_addr  = l1_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            sid_q      <= '0;
            base_q     <= '0;
            split_q    <= '0;
            two_lvl_q  <= 1'b0;
            done       <= 1'b0;
            entry_addr <= '0;
            fault      <= 1'b0;
            fault_code <= FLT_NONE;
            fault_addr <= '0;
        end else begin
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_code <= FLT_NONE;
            fault_addr <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (lk_valid) begin
                        sid_q     <= lk_sid;
                        base_q    <= tbl_base;
                        two_lvl_q <= (cfg_format(cfg_word) == FMT_TWO_LEVEL);
                        split_q   <= cfg_split(cfg_word);
                        state_q   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (sid_oob) begin
                        fault      <= 1'b1;
                        fault_code <= FLT_BAD_SID;
                        state_q    <= ST_IDLE;
                    end else if (!two_lvl_q) begin
                        done       <= 1'b1;
                        entry_addr <= lin_addr;
                        state_q    <= ST_IDLE;
                    end else begin
                        state_q    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rd_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        state_q <= ST_IDLE;
                        if (rd_rsp_err) begin
                            fault      <= 1'b1;
                            fault_code <= FLT_FETCH;
                            fault_addr <= l1_addr;
                        end else if (span_zero) begin
                            fault      <= 1'b1;
                            fault_code <= FLT_BAD_SID;
                        end else if (l2_over) begin
                            fault      <= 1'b1;
                            fault_code <= FLT_BAD_ENTRY;
                        end else begin
                            done       <= 1'b1;
                            entry_addr <= ent_addr;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stream_entry_locator_chk.sv
module stream_entry_locator_chk #(
    parameter int SID_W  = 32,
    parameter int ADDR_W = 48,
    parameter int CFG_W  = 32,
    parameter int DESC_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              done,
    input logic [ADDR_W-1:0] entry_addr,
    input logic              fault,
    input logic [1:0]        fault_code
);
    // R9
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_ready |=> !lk_ready);

    // R9
    strobe_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |-> lk_ready);

    // R9
    fault_code_set_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_code != 2'd0));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R5
    req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> !lk_ready);

    // R7
    entry_align_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (entry_addr[5:0] == 6'd0));

endmodule

bind stream_entry_locator stream_entry_locator_chk #(
    .SID_W(SID_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .DESC_W(DESC_W)
) chk_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .done(done), .entry_addr(entry_addr),
    .fault(fault), .fault_code(fault_code)
);

// File: tb/stream_entry_locator_tb_top.sv
`timescale 1ns/1ps
module stream_entry_locator_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [31:0] lk_sid = '0;
    logic [47:0] tbl_base = '0;
    logic [31:0] tbl_cfg = '0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [47:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        rd_rsp_err = 1'b0;
    logic        done;
    logic [47:0] entry_addr;
    logic        fault;
    logic [1:0]  fault_code;
    logic [47:0] fault_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int req_cnt  = 0;
    logic [47:0] req_addr_cap = '0;
    logic [63:0] cur_desc = '0;
    bit          cur_err  = 1'b0;
    bit          req_seen = 1'b0;
    int          cdown    = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    stream_entry_locator dut_i (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_sid(lk_sid), .tbl_base(tbl_base), .tbl_cfg(tbl_cfg),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .done(done), .entry_addr(entry_addr), .fault(fault),
        .fault_code(fault_code), .fault_addr(fault_addr)
    );

    // memory responder with random stalls and latency
    always @(negedge clk) begin
        if (rd_rsp_valid) rd_rsp_valid = 1'b0;
        if (req_seen) begin
            if (cdown == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = cur_desc;
                rd_rsp_err   = cur_err;
                req_seen     = 1'b0;
            end else begin
                cdown--;
            end
        end
        rd_req_ready = (($urandom % 4) != 0);
        if (!req_seen && rd_req_valid && rd_req_ready) begin
            req_seen     = 1'b1;
            req_cnt++;
            req_addr_cap = rd_req_addr;
            cdown        = $urandom % 3;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(
        input  logic [31:0] sid, input logic [47:0] base, input logic [31:0] cfg,
        input  logic [63:0] desc, input bit err,
        output logic [1:0] code, output logic [47:0] addr,
        output bit mem, output logic [47:0] l1a);
        logic [47:0] bm;
        int          split;
        int          span;
        logic [31:0] l2;
        bm    = base & ~48'h3f;
        split = int'(cfg[10:6]);
        span  = int'(desc[4:0]);
        mem = 1'b0; l1a = '0; code = 2'd0; addr = '0;
        if (sid >= 32'h10000) begin code = 2'd1; return; end
        if (cfg[17:16] != 2'd1) begin addr = bm + (48'(sid) << 6); return; end
        mem = 1'b1;
        l1a = bm + (48'(sid >> split) << 3);
        if (err) begin code = 2'd3; addr = l1a; return; end
        if (span == 0) begin code = 2'd1; return; end
        l2 = sid & ((32'h1 << split) - 32'h1);
        if (64'(l2) > ((64'h1 << span) - 64'h1)) code = 2'd2;
        else addr = {desc[47:6], 6'b0} + (48'(l2) << 6);
    endfunction

    task automatic run(input logic [31:0] sid, input logic [47:0] base, input logic [31:0] cfg,
                       input logic [63:0] desc, input bit err, input string tag);
        logic [1:0]  e_code;
        logic [47:0] e_addr;
        logic [47:0] e_l1;
        bit          e_mem;
        logic [1:0]  g_code;
        logic [47:0] g_addr;
        int          n0;
        int          w;
        model(sid, base, cfg, desc, err, e_code, e_addr, e_mem, e_l1);
        cur_desc = desc;
        cur_err  = err;
        n0 = req_cnt;
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1; lk_sid = sid; tbl_base = base; tbl_cfg = cfg;
        @(negedge clk);
        lk_valid = 1'b0;
        tbl_base = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        tbl_cfg  = $urandom;
        lk_sid   = $urandom;
        w = 0;
        while (!(done || fault) && w < 60) begin @(negedge clk); w++; end
        chk(w < 60, {tag, " R9 strobe"}, 64'(w), 64'd60);
        g_code = fault ? fault_code : 2'd0;
        g_addr = fault ? fault_addr : entry_addr;
        chk(!(done && fault), {tag, " R9 excl"}, {62'd0, done, fault}, 64'd1);
        chk(g_code == e_code, {tag, " code"}, 64'(g_code), 64'(e_code));
        chk(g_addr == e_addr, {tag, " addr"}, 64'(g_addr), 64'(e_addr));
        chk((req_cnt - n0) == (e_mem ? 1 : 0), {tag, " R5 read count"}, 64'(req_cnt - n0), 64'(e_mem));
        if (e_mem) chk(req_addr_cap == e_l1, {tag, " R5 read addr"}, 64'(req_addr_cap), 64'(e_l1));
        chk(lk_ready == 1'b1, {tag, " R9 ready after"}, 64'(lk_ready), 64'd1);
    endtask

    initial begin : wdog
        int cyc;
        cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    localparam logic [31:0] TWO = 32'h0001_0000;

    function automatic logic [31:0] cfg2(input int split);
        return TWO | (32'(split) << 6);
    endfunction

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(lk_ready == 1'b1, "R1 ready", 64'(lk_ready), 64'd1);
        chk(done == 1'b0 && fault == 1'b0, "R1 strobes", {62'd0, done, fault}, 64'd0);
        chk(rd_req_valid == 1'b0, "R1 req", 64'(rd_req_valid), 64'd0);

        // R4 linear, masked base, first and last IDs
        run(32'h0, 48'h0000_1234_5000, 32'h0, 64'h0, 1'b0, "R4 lin sid0");
        run(32'hFFFF, 48'h0000_8000_003F, 32'h0, 64'h0, 1'b0, "R4 lin max");
        // R3 only format value 1 enables two-level
        run(32'h0123, 48'h1000, 32'h0002_0080, 64'h0, 1'b0, "R3 fmt2 linear");
        run(32'h0123, 48'h1000, 32'h0003_0080, 64'h0, 1'b0, "R3 fmt3 linear");
        // R2 out of range, both modes
        run(32'h0001_0000, 48'h2000, 32'h0, 64'h0, 1'b0, "R2 lin oob");
        run(32'h8000_0001, 48'h2000, cfg2(4), 64'h0000_0000_4000_0005, 1'b0, "R2 2lvl oob");
        // R5/R7 two-level normal, split 0
        run(32'h0042, 48'h0000_0010_0000, cfg2(0), 64'h0000_0ABC_DE00_0001, 1'b0, "R7 split0");
        // R7 boundary: index exactly 2^span-1 and one beyond
        run(32'h00A7, 48'h0000_0020_0000, cfg2(4), 64'h0000_0000_5000_0003, 1'b0, "R7 idx max");
        run(32'h00A8, 48'h0000_0020_0000, cfg2(4), 64'h0000_0000_5000_0003, 1'b0, "R7 idx over");
        // R6 span zero
        run(32'h0333, 48'h0000_0030_0000, cfg2(6), 64'h0000_0000_6000_0000, 1'b0, "R6 span0");
        // R6 pointer low bits ignored
        run(32'h0011, 48'h0000_0040_0000, cfg2(5), 64'h0000_0000_7000_003F, 1'b0, "R6 ptr mask");
        // R8 fetch fault
        run(32'h1234, 48'h0000_0050_0017, cfg2(3), 64'h0000_0000_8000_0008, 1'b1, "R8 bus err");
        // R3 large split
        run(32'hFFFF, 48'h0000_0060_0000, cfg2(31), 64'h0000_0000_9000_0010, 1'b0, "R3 split31");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] sid;
            logic [31:0] cfg;
            logic [63:0] desc;
            logic [47:0] base;
            bit          err;
            sid  = (($urandom % 8) == 0) ? $urandom : ($urandom & 32'hFFFF);
            cfg  = ($urandom & ~32'h0003_07C0) | (32'($urandom % 4) << 16) | (32'($urandom % 20) << 6);
            if (($urandom % 2) == 0) cfg = (cfg & ~32'h0003_0000) | TWO;
            desc = {$urandom, $urandom};
            desc[4:0] = 5'($urandom % 18);
            base = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            base[47:40] = 8'h0;
            err  = (($urandom % 8) == 0);
            run(sid, base, cfg, desc, err, "R7 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule